// File: doc/BRIEF.md
# Load-Use Stall and Early Branch Steering Control

This block is the hazard and branch control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It looks at the instruction in decode and the instruction in execute. When execute holds a load whose destination is a register that the decode instruction actually reads, it freezes the program counter and the fetch/decode register, and tells the decode/execute register to take a bubble. The bubble is an instruction whose control fields are all zero. Every other dependence is assumed to be handled by operand forwarding elsewhere, so no other case stalls.

Conditional branches are resolved in decode by a small dedicated comparator that works on the two register operands. Fetch always continues sequentially. When a branch in decode turns out taken, the block flushes the fetched instruction to a NOP and sends the branch target to the program counter. A load-use stall takes precedence over a branch in the same cycle. The branch is evaluated again on the cycle after the stall clears, once the correct operand is available.

The block is purely combinational. All of its outputs follow from the current inputs in the same cycle, and it has no clock or state.

Top module: `hzc_pipe_ctrl`

## Requirements
- R1: `stall` condition: `ex_mem_read`=1 and a used source field of decode equals a nonzero `ex_rd`; then `idex_bubble`=1.
- R2: When `ex_rd` is 0, `idex_bubble` is 0 whatever the source fields and `ex_mem_read` are.
- R3: A source field whose use flag (`id_use_a` or `id_use_b`) is 0 does not take part in the comparison. Its register number has no effect on any output.
- R4: When `ex_mem_read` is 0, `idex_bubble` is 0.
- R5: `pc_we` and `ifid_we` are both 0 when a stall is active and both 1 otherwise.
- R6: `idex_bubble` is 1 exactly when a stall is active.
- R7: `id_br_kind` uses this encoding: 0 = no branch, 1 = equal, 2 = less-than, 3 = greater-than. The operands are compared as two's-complement signed values. The result is the branch condition.
- R8: When the condition holds and no stall is active, `br_taken`=1, `if_flush`=1 and `pc_next`=`id_br_target`. Otherwise `br_taken`=0, `if_flush`=0 and `pc_next`=`pc_seq`.
- R9: While a stall is active, `br_taken` and `if_flush` are 0 and `pc_next`=`pc_seq`, even if the branch condition holds.
- R10: With idle inputs (no load, no branch), all write enables are 1 and `idex_bubble`, `if_flush` and `br_taken` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_a | input | REG_AW | First source register number in decode |
| id_use_a | input | 1 | First source is read by the decode instruction |
| id_rs_b | input | REG_AW | Second source register number in decode |
| id_use_b | input | 1 | Second source is read by the decode instruction |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| id_opnd_a | input | DATA_W | First register operand in decode |
| id_opnd_b | input | DATA_W | Second register operand in decode |
| id_br_kind | input | 2 | Branch type of the decode instruction |
| id_br_target | input | PC_W | Branch target address |
| pc_seq | input | PC_W | Sequential next fetch address |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields entering execute |
| if_flush | output | 1 | Turn the fetched instruction into a NOP |
| br_taken | output | 1 | Branch in decode is taken |
| pc_next | output | PC_W | Selected next fetch address |

## Verification
The hardest case to reach is a branch whose condition holds while a load-use stall is active on one of its own operands. A directed test can hit it only by chance, because it needs a load in execute, a matching used source field and a branch kind that evaluates true, all at once. The bench runs a small configuration with four registers and three-bit operands and sweeps the full cross product of source numbers, use flags, destination, load flag, branch kind and both operands. Every stall-versus-taken overlap is therefore visited, along with register zero and the unused-field cases.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [1:0] {
    BRK_NONE = 2'd0,
    BRK_EQ   = 2'd1,
    BRK_LT   = 2'd2,
    BRK_GT   = 2'd3
  } brk_e;

endpackage

// File: rtl/hzc_src_match.sv
module hzc_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              src_used,
  input  logic [REG_AW-1:0] dst,
  output logic              hit
);

  logic dst_real;

  always_comb begin
    dst_real = (dst != '0);
    hit      = src_used && dst_real && (src == dst);
  end

  // R3: an unused field never reports a match
  always_comb begin
    a_r3_unused_quiet: assert (src_used || !hit)
      else $error("unused source produced a match");
  end

endmodule

// File: rtl/hzc_brcmp.sv
module hzc_brcmp
  import hzc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [1:0]        kind,
  output logic              cond
);

  brk_e kind_e;
  logic eq_f;
  logic lt_f;
  logic gt_f;

  always_comb begin
    kind_e = brk_e'(kind);
    eq_f   = (opnd_a == opnd_b);
    lt_f   = ($signed(opnd_a) < $signed(opnd_b));
    gt_f   = !eq_f && !lt_f;
    unique case (kind_e)
      BRK_EQ:  cond = eq_f;
      BRK_LT:  cond = lt_f;
      BRK_GT:  cond = gt_f;
      default: cond = 1'b0;
    endcase
  end

  // R7: no-branch kind never yields a condition
  always_comb begin
    a_r7_none_false: assert (kind != 2'd0 || !cond)
      else $error("no-branch kind produced a condition");
  end

endmodule

// File: rtl/hzc_steer.sv
module hzc_steer #(
  parameter int PC_W = 32
) (
  input  logic            stall,
  input  logic            cond,
  input  logic [PC_W-1:0] target,
  input  logic [PC_W-1:0] seq,
  output logic            pc_we,
  output logic            ifid_we,
  output logic            bubble,
  output logic            flush,
  output logic            taken,
  output logic [PC_W-1:0] pc_next
);

  always_comb begin
    pc_we   = !stall;
    ifid_we = !stall;
    bubble  = stall;
    taken   = cond && !stall;
    flush   = taken;
    pc_next = taken ? target : seq;
  end

endmodule

// File: rtl/hzc_pipe_ctrl.sv
module hzc_pipe_ctrl #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic [REG_AW-1:0] id_rs_a,
  input  logic              id_use_a,
  input  logic [REG_AW-1:0] id_rs_b,
  input  logic              id_use_b,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_mem_read,
  input  logic [DATA_W-1:0] id_opnd_a,
  input  logic [DATA_W-1:0] id_opnd_b,
  input  logic [1:0]        id_br_kind,
  input  logic [PC_W-1:0]   id_br_target,
  input  logic [PC_W-1:0]   pc_seq,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              idex_bubble,
  output logic              if_flush,
  output logic              br_taken,
  output logic [PC_W-1:0]   pc_next
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] src_num;
  logic [NSRC-1:0]             src_use;
  logic [NSRC-1:0]             src_hit;
  logic                        stall;
  logic                        cond;

  always_comb begin
    src_num[0] = id_rs_a;
    src_num[1] = id_rs_b;
    src_use[0] = id_use_a;
    src_use[1] = id_use_b;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzc_src_match #(.REG_AW(REG_AW)) i_match (
      .src      (src_num[g]),
      .src_used (src_use[g]),
      .dst      (ex_rd),
      .hit      (src_hit[g])
    );
  end

  always_comb stall = ex_mem_read && (|src_hit);

  hzc_brcmp #(.DATA_W(DATA_W)) i_brcmp (
    .opnd_a (id_opnd_a),
    .opnd_b (id_opnd_b),
    .kind   (id_br_kind),
    .cond   (cond)
  );

  hzc_steer #(.PC_W(PC_W)) i_steer (
    .stall   (stall),
    .cond    (cond),
    .target  (id_br_target),
    .seq     (pc_seq),
    .pc_we   (pc_we),
    .ifid_we (ifid_we),
    .bubble  (idex_bubble),
    .flush   (if_flush),
    .taken   (br_taken),
    .pc_next (pc_next)
  );

  always_comb begin
    // R2
    a_r2_zero_dst: assert (ex_rd != '0 || !idex_bubble)
      else $error("bubble with register zero as destination");
    // R4
    a_r4_no_load: assert (ex_mem_read || !idex_bubble)
      else $error("bubble without a load in execute");
    // R5
    a_r5_freeze: assert (idex_bubble == !pc_we && pc_we == ifid_we)
      else $error("freeze enables disagree with bubble");
    // R9
    a_r9_stall_wins: assert (!(idex_bubble && (if_flush || br_taken)))
      else $error("branch acted during a stall");
    // R8
    a_r8_redirect: assert (!if_flush || pc_next == id_br_target)
      else $error("flush without redirect to target");
  end

endmodule

// File: tb/test_hzc_pipe_ctrl.sv
`timescale 1ns/1ps
module test_hzc_pipe_ctrl;

  localparam int AW = 2;
  localparam int DW = 3;
  localparam int PW = 4;
  localparam logic [PW-1:0] TGT = 4'hA;
  localparam logic [PW-1:0] SEQ = 4'h5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] id_rs_a, id_rs_b, ex_rd;
  logic          id_use_a, id_use_b, ex_mem_read;
  logic [DW-1:0] id_opnd_a, id_opnd_b;
  logic [1:0]    id_br_kind;
  logic [PW-1:0] id_br_target, pc_seq;
  logic          pc_we, ifid_we, idex_bubble, if_flush, br_taken;
  logic [PW-1:0] pc_next;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  hzc_pipe_ctrl #(.REG_AW(AW), .DATA_W(DW), .PC_W(PW)) i_hzc_pipe_ctrl (
    .id_rs_a(id_rs_a), .id_use_a(id_use_a), .id_rs_b(id_rs_b), .id_use_b(id_use_b),
    .ex_rd(ex_rd), .ex_mem_read(ex_mem_read), .id_opnd_a(id_opnd_a),
    .id_opnd_b(id_opnd_b), .id_br_kind(id_br_kind), .id_br_target(id_br_target),
    .pc_seq(pc_seq), .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
    .if_flush(if_flush), .br_taken(br_taken), .pc_next(pc_next)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      if (n_bad < 20)
        $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    id_br_target = TGT;
    pc_seq       = SEQ;
    // R10 idle
    id_rs_a = 2'd1; id_rs_b = 2'd2; id_use_a = 1'b1; id_use_b = 1'b1;
    ex_rd = 2'd1; ex_mem_read = 1'b0; id_opnd_a = '0; id_opnd_b = '0;
    id_br_kind = 2'd0;
    #1.25;
    chk("R10", "pc_we", int'(pc_we), 1);
    chk("R10", "ifid_we", int'(ifid_we), 1);
    chk("R10", "idex_bubble", int'(idex_bubble), 0);
    chk("R10", "if_flush", int'(if_flush), 0);
    chk("R10", "br_taken", int'(br_taken), 0);

    for (int ra = 0; ra < 4; ra++)
    for (int rb = 0; rb < 4; rb++)
    for (int ua = 0; ua < 2; ua++)
    for (int ub = 0; ub < 2; ub++)
    for (int rd = 0; rd < 4; rd++)
    for (int ld = 0; ld < 2; ld++)
    for (int k = 0; k < 4; k++)
    for (int va = 0; va < 8; va++)
    for (int vb = 0; vb < 8; vb++) begin
      int sa, sb;
      bit hz, cnd, tk;
      id_rs_a = AW'(ra); id_rs_b = AW'(rb);
      id_use_a = ua[0]; id_use_b = ub[0];
      ex_rd = AW'(rd); ex_mem_read = ld[0];
      id_br_kind = 2'(k);
      id_opnd_a = DW'(va); id_opnd_b = DW'(vb);
      sa = (va >= 4) ? va - 8 : va;
      sb = (vb >= 4) ? vb - 8 : vb;
      hz = (ld == 1) && (rd != 0) && ((ua == 1 && ra == rd) || (ub == 1 && rb == rd));
      case (k)
        1: cnd = (sa == sb);
        2: cnd = (sa < sb);
        3: cnd = (sa > sb);
        default: cnd = 1'b0;
      endcase
      tk = cnd && !hz;
      #1;
      if (rd == 0)
        chk("R2", "idex_bubble", int'(idex_bubble), 0);
      else if (ld == 0)
        chk("R4", "idex_bubble", int'(idex_bubble), 0);
      else if (ua == 0 || ub == 0)
        chk("R3", "idex_bubble", int'(idex_bubble), int'(hz));
      else
        chk("R1", "idex_bubble", int'(idex_bubble), int'(hz));
      chk("R6", "idex_bubble", int'(idex_bubble), int'(hz));
      chk("R5", "pc_we", int'(pc_we), int'(!hz));
      chk("R5", "ifid_we", int'(ifid_we), int'(!hz));
      if (hz && cnd) begin
        chk("R9", "br_taken", int'(br_taken), 0);
        chk("R9", "if_flush", int'(if_flush), 0);
        chk("R9", "pc_next", int'(pc_next), int'(SEQ));
      end else begin
        chk("R7", "br_taken", int'(br_taken), int'(tk));
        chk("R8", "if_flush", int'(if_flush), int'(tk));
        chk("R8", "pc_next", int'(pc_next), tk ? int'(TGT) : int'(SEQ));
      end
    end
    finish_run();
  end

endmodule